// File: doc/BRIEF.md
# Serial Flag-Offset Loader

This block holds the two threshold offsets that a FIFO's partial-flag logic compares against its fill level. One sets the almost-empty threshold and the other sets the almost-full threshold. New values arrive one bit at a time on a serial data input. A bit is sampled on the write clock only while the active-low load strobe and the active-low serial-enable strobe are both asserted.

A programming pass is a string of twice the offset width. It carries the almost-empty offset first, least significant bit first, and then the almost-full offset in the same way. The string may be paused at any bit by raising either strobe, for example to let ordinary FIFO writes take place. Loading resumes with the next bit once both strobes are low again. The incoming bits collect in a shadow register. Both offsets change together on the write-clock edge that captures the last bit.

From the first bit of a pass until the pass completes, the two validity qualifiers are low. The almost-full qualifier lives in the write-clock domain and returns high two write-clock edges after completion. The almost-empty qualifier lives in the read-clock domain and returns high two read-clock edges after completion.

Top module: `sflag_ofs_loader`

## Requirements
- R1: On each rising `wr_clk` edge with `rst_n` high, `load_n` low and `sen_n` low, exactly one bit of `sdi` is captured.
- R2: A pass is 2*W captured bits. Captured bit k (counting from 0) becomes `empty_ofs[k]` for k < W and `full_ofs[k-W]` for k >= W.
- R3: While `load_n` is high, or `sen_n` is high, no bit is captured and `sdi` has no effect. With no pass open, `full_ofs_ok` stays high.
- R4: A pass interrupted by either strobe going high continues with the next bit of the sequence once both strobes are low again. It does not restart.
- R5: `empty_ofs` and `full_ofs` keep their old values throughout a pass. Both take their new values together on the edge that captures bit 2*W-1.
- R6: `full_ofs_ok` is low from the edge that captures bit 0 of a pass until completion. `empty_ofs_ok` is low before the final bit of any pass longer than a few read-clock cycles.
- R7: After the completing edge, `full_ofs_ok` is low after the first following `wr_clk` edge and high after the second. `empty_ofs_ok` is low after the first following `rd_clk` edge and high after the second.
- R8: A synchronous reset (`rst_n` low) clears the bit position to 0, loads `DEF_EMPTY`/`DEF_FULL`, and sets both qualifiers high. A partly entered pass is discarded.
- R9: The bit captured after a completed pass is bit 0 of a new pass. A new pass must enter the whole string again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; bits are captured on its rising edge |
| rd_clk | input | 1 | Read clock; domain of the almost-empty qualifier |
| rst_n | input | 1 | Synchronous active-low reset, held across edges of both clocks |
| load_n | input | 1 | Active-low load strobe |
| sen_n | input | 1 | Active-low serial-enable strobe |
| sdi | input | 1 | Serial offset data |
| empty_ofs | output | W | Active almost-empty offset |
| full_ofs | output | W | Active almost-full offset |
| full_ofs_ok | output | 1 | Almost-full offset valid (write-clock domain) |
| empty_ofs_ok | output | 1 | Almost-empty offset valid (read-clock domain) |

## Verification
The offsets are due at the first write-clock falling edge after the capturing edge of the final bit. The bench samples them there, at the same point where it raises the strobes. The almost-full qualifier is sampled at the falling edges after completion plus one and completion plus two, and is expected low, then high. A separate thread started before the completing edge counts the read-clock edges that follow it and samples one time unit after each. This gives the low-then-high pattern of the almost-empty qualifier without depending on the ratio between the clocks. Pauses of every strobe combination, with random serial data, are inserted between bits at random.

// File: rtl/sfl_pkg.sv
// Shared types for the serial flag-offset loader.
// Assumes: used only by the sfl_* modules.
package sfl_pkg;
    // Whether a programming pass is under way.
    typedef enum logic {
        PASS_DONE = 1'b0,
        PASS_OPEN = 1'b1
    } pass_state_t;
endpackage

// File: rtl/sfl_shift_seq.sv
// Serial shift sequencer: counts bit positions, assembles a shadow copy of
// both offsets, and commits it on the last bit of a pass.
// Assumes: shift_en is already the qualified capture enable in wr_clk domain.
module sfl_shift_seq
    import sfl_pkg::*;
#(
    parameter int unsigned    W         = 16,
    parameter logic [W-1:0]   DEF_EMPTY = W'(8),
    parameter logic [W-1:0]   DEF_FULL  = W'(8)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         sdi,
    output logic [W-1:0] empty_ofs,
    output logic [W-1:0] full_ofs,
    output logic         pass_open
);
    localparam int unsigned TOTAL = 2 * W;
    localparam int unsigned CW    = $clog2(TOTAL);
    localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

    logic [CW-1:0]    cnt;
    logic [TOTAL-1:0] shadow;
    pass_state_t      state;

    // Capture one bit per enabled edge; commit both offsets on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            shadow    <= '0;
            state     <= PASS_DONE;
            empty_ofs <= DEF_EMPTY;
            full_ofs  <= DEF_FULL;
        end else if (shift_en) begin
            if (cnt == LAST) begin
                {full_ofs, empty_ofs} <= {sdi, shadow[TOTAL-2:0]};
                cnt   <= '0;
                state <= PASS_DONE;
            end else begin
                shadow[cnt] <= sdi;
                cnt   <= cnt + CW'(1);
                state <= PASS_OPEN;
            end
        end
    end

    // Pass-in-progress indication for the validity logic.
    assign pass_open = (state == PASS_OPEN);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cnt) < TOTAL)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(cnt) && $stable(shadow))); // R3
    AST_MIDPASS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && cnt != LAST) |=> ($stable(empty_ofs) && $stable(full_ofs) && pass_open)); // R5
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && cnt == LAST) |=> (!pass_open && cnt == '0)); // R9
endmodule

// File: rtl/sfl_valid_wr.sv
// Write-domain validity: almost-full qualifier drops as soon as a pass opens
// and returns two write-clock edges after the pass completes.
// Assumes: pass_open comes from a wr_clk register.
module sfl_valid_wr (
    input  logic clk,
    input  logic rst_n,
    input  logic pass_open,
    output logic full_ok
);
    logic s1, s2;

    // Two-edge delay of the "pass complete" level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= !pass_open;
            s2 <= s1;
        end
    end

    // Invalid immediately while open, valid after the delay otherwise.
    assign full_ok = s2 && !pass_open;

    AST_FULL_RISE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_ok) |-> ($past(!pass_open, 1) && $past(!pass_open, 2))); // R7
    AST_FULL_LOW_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pass_open) |=> !full_ok); // R7
    AST_FULL_LOW_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_open) |-> !full_ok); // R6
endmodule

// File: rtl/sfl_sync_rd.sv
// Two-flop synchronizer carrying the "pass complete" level into the read
// clock domain as the almost-empty qualifier.
// Assumes: d is a glitch-free register output from the write domain.
module sfl_sync_rd (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic r1;

    // Two-stage resynchronization, reset to valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1 <= 1'b1;
            q  <= 1'b1;
        end else begin
            r1 <= d;
            q  <= r1;
        end
    end

    AST_SYNC_RISE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(r1)); // R7
endmodule

// File: rtl/sflag_ofs_loader.sv
// Serial flag-offset loader top: qualifies the strobes, sequences the bit
// string, and produces per-domain validity qualifiers for both offsets.
// Assumes: rst_n is synchronous and held low across edges of both clocks.
module sflag_ofs_loader #(
    parameter int unsigned  W         = 16,
    parameter logic [W-1:0] DEF_EMPTY = W'(8),
    parameter logic [W-1:0] DEF_FULL  = W'(8)
) (
    input  logic         wr_clk,
    input  logic         rd_clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic         sen_n,
    input  logic         sdi,
    output logic [W-1:0] empty_ofs,
    output logic [W-1:0] full_ofs,
    output logic         full_ofs_ok,
    output logic         empty_ofs_ok
);
    logic shift_en;
    logic pass_open;

    // A bit is taken only when both strobes are asserted.
    assign shift_en = !load_n && !sen_n;

    sfl_shift_seq #(.W(W), .DEF_EMPTY(DEF_EMPTY), .DEF_FULL(DEF_FULL)) u_seq (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .sdi       (sdi),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .pass_open (pass_open)
    );

    sfl_valid_wr u_vwr (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .pass_open (pass_open),
        .full_ok   (full_ofs_ok)
    );

    sfl_sync_rd u_vrd (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (!pass_open),
        .q     (empty_ofs_ok)
    );

    AST_STROBE_GATES: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (load_n || sen_n) |=> ($stable(empty_ofs) && $stable(full_ofs))); // R3
endmodule

// File: tb/sim_sflag_ofs_loader.sv
module sim_sflag_ofs_loader;
    localparam int unsigned  W     = 16;
    localparam logic [W-1:0] DEF_E = 16'h0010;
    localparam logic [W-1:0] DEF_F = 16'h0020;

    logic wclk = 1'b0, rclk = 1'b0;
    logic rst_n = 1'b0, load_n = 1'b1, sen_n = 1'b1, sdi = 1'b0;
    logic [W-1:0] empty_ofs, full_ofs;
    logic full_ofs_ok, empty_ofs_ok;
    int n_chk = 0, n_fail = 0;
    logic [W-1:0] cur_e, cur_f;

    sflag_ofs_loader #(.W(W), .DEF_EMPTY(DEF_E), .DEF_FULL(DEF_F)) u0 (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .load_n(load_n),
        .sen_n(sen_n), .sdi(sdi), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .full_ofs_ok(full_ofs_ok), .empty_ofs_ok(empty_ofs_ok)
    );

    // 125 MHz write clock (rising at 4+8k); read clock rising at 7+12k.
    initial forever #4 wclk = ~wclk;
    initial begin #1; forever #6 rclk = ~rclk; end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected string: empty offset LSB first, then full offset.
    function automatic logic [2*W-1:0] pass_bits(logic [W-1:0] e, logic [W-1:0] f);
        return {f, e};
    endfunction

    // Idle cycles with a random strobe combination and random sdi.
    task automatic pause(int n);
        int mode = $urandom_range(2, 0);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            load_n = (mode != 1);
            sen_n  = (mode != 2);
            sdi    = 1'($urandom);
        end
    endtask

    task automatic do_reset();
        @(negedge wclk);
        rst_n = 1'b0; load_n = 1'b1; sen_n = 1'b1;
        repeat (5) @(negedge wclk);
        rst_n = 1'b1;
        cur_e = DEF_E; cur_f = DEF_F;
    endtask

    // One complete pass with random pauses, checking offsets and latencies.
    task automatic run_pass(logic [W-1:0] e, logic [W-1:0] f, int pct);
        logic [2*W-1:0] b = pass_bits(e, f);
        for (int k = 0; k < int'(2*W) - 1; k++) begin
            if (k > 0 && $urandom_range(99, 0) < pct) pause($urandom_range(4, 1));
            @(negedge wclk);
            if (k == 1) begin
                chk("R6 full_ok low after bit 0", 32'(full_ofs_ok), 32'd0);
                chk("R5 empty_ofs held mid-pass", 32'(empty_ofs), 32'(cur_e));
            end
            load_n = 1'b0; sen_n = 1'b0; sdi = b[k];
        end
        if ($urandom_range(99, 0) < pct) pause(3);
        @(negedge wclk);
        chk("R6 empty_ok low before last bit", 32'(empty_ofs_ok), 32'd0);
        chk("R5 full_ofs held before last bit", 32'(full_ofs), 32'(cur_f));
        load_n = 1'b0; sen_n = 1'b0; sdi = b[2*W-1];
        fork
            begin
                @(posedge wclk);
                @(negedge wclk);
                load_n = 1'b1; sen_n = 1'b1;
                chk("R2 empty_ofs order", 32'(empty_ofs), 32'(e));
                chk("R1 R4 full_ofs after pass", 32'(full_ofs), 32'(f));
                chk("R7 full_ok E+0", 32'(full_ofs_ok), 32'd0);
                @(negedge wclk);
                chk("R7 full_ok E+1", 32'(full_ofs_ok), 32'd0);
                @(negedge wclk);
                chk("R7 full_ok E+2", 32'(full_ofs_ok), 32'd1);
            end
            begin
                @(posedge wclk);
                @(posedge rclk); #1;
                chk("R7 empty_ok rd+1", 32'(empty_ofs_ok), 32'd0);
                @(posedge rclk); #1;
                chk("R7 empty_ok rd+2", 32'(empty_ofs_ok), 32'd1);
            end
        join
        cur_e = e; cur_f = f;
    endtask

    initial begin
        repeat (200000) @(posedge wclk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd771));
        do_reset();
        @(negedge wclk);
        chk("R8 reset empty_ofs", 32'(empty_ofs), 32'(DEF_E));
        chk("R8 reset full_ofs", 32'(full_ofs), 32'(DEF_F));
        chk("R8 reset full_ok", 32'(full_ofs_ok), 32'd1);
        chk("R8 reset empty_ok", 32'(empty_ofs_ok), 32'd1);
        // R3: one strobe only, toggling sdi: nothing captured.
        for (int i = 0; i < 12; i++) begin
            @(negedge wclk);
            load_n = (i < 6) ? 1'b0 : 1'b1;
            sen_n  = (i < 6) ? 1'b1 : 1'b0;
            sdi    = 1'(i);
        end
        @(negedge wclk); load_n = 1'b1; sen_n = 1'b1;
        @(negedge wclk);
        chk("R3 full_ok with one strobe", 32'(full_ofs_ok), 32'd1);
        chk("R3 offsets with one strobe", 32'(empty_ofs), 32'(DEF_E));
        // Directed passes; consecutive passes exercise R9.
        run_pass(16'hA5C3, 16'h0001, 40);
        run_pass(16'h0000, 16'hFFFF, 0);
        run_pass(16'hFFFF, 16'h0000, 60);
        // R8: partial pass discarded by reset.
        for (int k = 0; k < 5; k++) begin
            @(negedge wclk); load_n = 1'b0; sen_n = 1'b0; sdi = 1'b1;
        end
        do_reset();
        @(negedge wclk);
        chk("R8 reset mid-pass offsets", 32'(full_ofs), 32'(DEF_F));
        chk("R8 reset mid-pass full_ok", 32'(full_ofs_ok), 32'd1);
        run_pass(16'h1234, 16'h8765, 20);
        for (int r = 0; r < 15; r++)
            run_pass(W'($urandom), W'($urandom), 30);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule